// File: doc/BRIEF.md
# Edge/Level Interrupt Request Capture

This block turns eight synchronous interrupt request lines into a vector of pending requests for a downstream priority resolver. Each line runs in one of two trigger modes. In edge mode a request is latched when the line is seen high after having been seen low, and it stays latched until it is acknowledged. In level mode the pending bit simply follows the line.

The mode of each line is held in a trigger-select register that a bus port can write and read. A write only reaches the bits allowed by a fixed per-instance writable mask, so some lines can be locked to edge mode. The default mask is 0xF8; a secondary instance would use 0xDE. An acknowledge strobe with a line index retires an edge-mode request.

There are two resets. The power-on reset clears everything. The controller reset clears the pending and edge-history state but keeps the trigger-select setting.

Top module: `irq_capture`

## Requirements
- R1: While and after power-on reset (`por_n` low, asynchronous), `pending` is 0 and `trig_rdata` is 0. All lines are then in edge mode.
- R2: A line whose trigger-select bit is 1 (level mode) has its `pending` bit equal to the value `req_in` had at the previous rising clock edge.
- R3: A line whose trigger-select bit is 0 (edge mode) sets its `pending` bit one cycle after it is sampled high following a low sample. A later low sample does not clear the bit.
- R4: In edge mode, a line that is held high does not set `pending` again after it has been acknowledged. A new request needs a low sample first.
- R5: `ack_valid` with `ack_idx` = i clears `pending[i]` on the next cycle if line i is in edge mode. It leaves `pending[i]` set if line i is in level mode. It never affects other lines.
- R6: If an acknowledge and a new rising request on the same edge-mode line fall in the same cycle, the new request wins and `pending` stays 1.
- R7: A trigger-select write stores `trig_wdata & WMASK` (default 0xF8, so lines 0 to 2 stay edge mode). `trig_rdata` shows the stored value at all times without side effects. The new mode governs capture from the cycle after the write.
- R8: `ctl_rst` clears `pending` and all edge-history bits on the next cycle and leaves the trigger-select register unchanged. An edge-mode line that is still high afterwards is therefore captured again. A trigger-select write in the same cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ctl_rst | input | 1 | Controller reset, synchronous, active high |
| req_in | input | 8 | Synchronous interrupt request lines |
| trig_we | input | 1 | Trigger-select write strobe |
| trig_wdata | input | 8 | Trigger-select write data, 1 = level mode |
| trig_rdata | output | 8 | Trigger-select register contents |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 3 | Index of the acknowledged line |
| pending | output | 8 | Pending request vector |

## Verification
An acknowledge and a new rising request can hit the same edge-mode line in the same cycle. A controller reset can also coincide with a trigger-select write, or with lines that are held high. The bench provokes both collisions on purpose in directed steps. It then repeats them many times in a long random sweep in which acknowledges, writes and controller resets are scattered across changing request patterns. Each cycle the outputs are compared with a bench model that applies the requirement rules in order: the controller reset first, then the acknowledge clear, then the new edge set.

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int NLINES = 8,
  parameter logic [NLINES-1:0] WMASK = 8'hF8,
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ctl_rst,
  input  logic [NLINES-1:0] req_in,
  input  logic              trig_we,
  input  logic [NLINES-1:0] trig_wdata,
  output logic [NLINES-1:0] trig_rdata,
  input  logic              ack_valid,
  input  logic [IW-1:0]     ack_idx,
  output logic [NLINES-1:0] pending
);

  logic [NLINES-1:0] trig_q, hist_q, pend_q, ack_vec, rise;

  assign ack_vec    = ack_valid ? ({{(NLINES-1){1'b0}}, 1'b1} << ack_idx) : '0;
  assign rise       = req_in & ~hist_q;
  assign trig_rdata = trig_q;
  assign pending    = pend_q;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)       trig_q <= '0;
    else if (trig_we) trig_q <= trig_wdata & WMASK;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      hist_q <= '0;
      pend_q <= '0;
    end else if (ctl_rst) begin
      hist_q <= '0;
      pend_q <= '0;
    end else begin
      hist_q <= req_in;
      pend_q <= (trig_q & req_in) | (~trig_q & ((pend_q & ~ack_vec) | rise));
    end

  a_r2_level_follows: assert property (@(posedge clk) disable iff (!por_n)
    !ctl_rst |=> ((pending & $past(trig_q)) == ($past(req_in) & $past(trig_q))));

  a_r3_edge_holds: assert property (@(posedge clk) disable iff (!por_n)
    (!ctl_rst && !ack_valid) |=> (((pending & $past(pend_q)) & ~$past(trig_q)) == ($past(pend_q) & ~$past(trig_q))));

  a_r5_level_survives_ack: assert property (@(posedge clk) disable iff (!por_n)
    (ack_valid && !ctl_rst && trig_q[ack_idx] && req_in[ack_idx]) |=> pending[$past(ack_idx)]);

  a_r5_edge_ack_clears: assert property (@(posedge clk) disable iff (!por_n)
    (ack_valid && !ctl_rst && !trig_q[ack_idx] && !rise[ack_idx]) |=> !pending[$past(ack_idx)]);

  a_r6_new_edge_wins: assert property (@(posedge clk) disable iff (!por_n)
    (ack_valid && !ctl_rst && !trig_q[ack_idx] && rise[ack_idx]) |=> pending[$past(ack_idx)]);

  a_r7_mask_respected: assert property (@(posedge clk) disable iff (!por_n)
    (trig_rdata & ~WMASK) == '0);

  a_r8_ctl_clears: assert property (@(posedge clk) disable iff (!por_n)
    ctl_rst |=> (pending == '0));

  a_r8_trig_kept: assert property (@(posedge clk) disable iff (!por_n)
    (ctl_rst && !trig_we) |=> $stable(trig_rdata));

endmodule

// File: tb/test_irq_capture.sv
module test_irq_capture;
  logic       clk = 0;
  logic       por_n = 0;
  logic       ctl_rst = 0;
  logic [7:0] req_in = 0;
  logic       trig_we = 0;
  logic [7:0] trig_wdata = 0;
  logic [7:0] trig_rdata;
  logic       ack_valid = 0;
  logic [2:0] ack_idx = 0;
  logic [7:0] pending;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_p = 0, m_h = 0, m_t = 0;

  always #5 clk = ~clk;

  irq_capture i_irq_capture (
    .clk(clk), .por_n(por_n), .ctl_rst(ctl_rst), .req_in(req_in),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .trig_rdata(trig_rdata),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .pending(pending));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    logic [7:0] np = m_p, nh = m_h, nt = m_t;
    for (int i = 0; i < 8; i++) begin
      if (ctl_rst) begin
        np[i] = 0; nh[i] = 0;
      end else if (m_t[i]) begin
        np[i] = req_in[i]; nh[i] = req_in[i];
      end else begin
        if (ack_valid && ack_idx == 3'(i)) np[i] = 0;
        if (req_in[i] && !m_h[i]) np[i] = 1;
        nh[i] = req_in[i];
      end
    end
    if (trig_we) nt = trig_wdata & 8'hF8;
    @(posedge clk); #1;
    m_p = np; m_h = nh; m_t = nt;
    trig_we = 0; ack_valid = 0; ctl_rst = 0;
    chk("R2/R3 model pending", pending, m_p);
    chk("R7 model trig", trig_rdata, m_t);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    #23;
    chk("R1 pending in reset", pending, 8'h00);
    chk("R1 trig in reset", trig_rdata, 8'h00);
    por_n = 1;
    cyc();
    chk("R1 pending after reset", pending, 8'h00);

    for (int v = 0; v < 256; v++) begin
      trig_we = 1; trig_wdata = 8'(v);
      cyc();
      chk("R7 masked write", trig_rdata, 8'(v) & 8'hF8);
      #2 chk("R7 read no side effect", trig_rdata, 8'(v) & 8'hF8);
    end

    trig_we = 1; trig_wdata = 8'h08; cyc();
    req_in = 8'h10; cyc(); cyc();
    chk("R3 edge set", pending, 8'h10);
    req_in = 8'h00; cyc();
    chk("R3 falling keeps", pending, 8'h10);
    ack_valid = 1; ack_idx = 4; cyc();
    chk("R5 edge ack clears", pending, 8'h00);
    req_in = 8'h10; cyc(); cyc();
    ack_valid = 1; ack_idx = 4; cyc(); cyc();
    chk("R4 held high no reassert", pending, 8'h00);
    req_in = 8'h08; cyc(); cyc();
    chk("R2 level set", pending, 8'h08);
    ack_valid = 1; ack_idx = 3; cyc();
    chk("R5 level keeps on ack", pending, 8'h08);
    req_in = 8'h00; cyc();
    chk("R2 level clears", pending, 8'h00);
    req_in = 8'h01; cyc();
    chk("R5 setup line0", pending, 8'h01);
    req_in = 8'h00; cyc();
    req_in = 8'h01; ack_valid = 1; ack_idx = 0; cyc();
    chk("R6 new edge wins over ack", pending, 8'h01);
    req_in = 8'h21; ack_valid = 1; ack_idx = 2; cyc();
    chk("R5 other line untouched", pending, 8'h21);
    ctl_rst = 1; trig_we = 1; trig_wdata = 8'hFF; cyc();
    chk("R8 ctl reset clears", pending, 8'h00);
    chk("R8 same-cycle write lands", trig_rdata, 8'hF8);
    req_in = 8'h03; cyc();
    chk("R8 recapture after ctl reset", pending, 8'h03);
    ctl_rst = 1; cyc();
    chk("R8 trig kept", trig_rdata, 8'hF8);

    for (int n = 0; n < 6000; n++) begin
      req_in = 8'($urandom);
      if ($urandom_range(0, 3) == 0) begin ack_valid = 1; ack_idx = 3'($urandom); end
      if ($urandom_range(0, 15) == 0) begin trig_we = 1; trig_wdata = 8'($urandom); end
      if ($urandom_range(0, 63) == 0) ctl_rst = 1;
      cyc();
    end
    summary();
  end
endmodule